// File: doc/BRIEF.md
# Interleaved Partial-Sum Streaming Accumulator

This block adds up a stream of unsigned integer operands and accepts one operand on every clock, even though its adder needs several cycles to produce a result. It does this by keeping a ring of partial sums. Each accepted operand is added to the partial sum at the head of the ring. That result travels through the adder pipeline and then through a short set of storage slots, and it reaches the head again exactly `DEPTH` accepted operands later. No addition ever needs the result of the one issued just before it.

A run begins with a start pulse that carries the element count. Every partial sum is cleared at that point. The block then takes operands on each cycle where valid is high until it has seen the requested count. In the drain phase that follows, the ring is rotated once more, and each partial sum is folded into a single-cycle reduction register as it passes the head. The total appears together with a one-cycle done pulse, and it stays on the output until the next run completes. The adder latency (`LAT`) may be any value from 1 up to `DEPTH`.

Top module: `psum_ring_accum`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: When a run completes, `result_o` holds the sum of the run's operands, each zero-extended to `SUM_W` bits, taken modulo 2^`SUM_W`.
- R3: With `valid_i` held high, one operand is accepted on every clock edge while running. `done_o` is high exactly in the cycle that follows the `DEPTH`-th clock edge after the edge that accepted the last operand.
- R4: Counts larger than `DEPTH` give the correct total: partial sums that wrap around the ring are kept, not overwritten.
- R5: While running, a cycle with `valid_i` low neither shifts the ring nor adds, and it loses no partial sum. Only cycles with `valid_i` high count toward the element count.
- R6: A start pulse with `count_i` equal to 0 consumes no operands. It sets `result_o` to 0 and raises `done_o` in the cycle after the start edge.
- R7: `done_o` is a single-cycle pulse. `result_o` changes only together with `done_o` and holds its value until the next completion.
- R8: `valid_i` is ignored outside the accepting phase (while idle and while draining). A start pulse that arrives while a run is active is ignored.
- R9: Each start clears all partial sums, so a run's total does not depend on any earlier run.
- R10: Counts smaller than or equal to `DEPTH`, including a count of 1, give the correct total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; sampled only while idle |
| count_i | input | CNT_W | Number of operands in the run; sampled with start_i |
| valid_i | input | 1 | Operand on data_i is offered this cycle |
| data_i | input | DATA_W | Unsigned operand |
| result_o | output | SUM_W | Total of the most recently completed run |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The assertions assume the following about the inputs: `count_i` matters only on a start edge while the block is idle, and `valid_i` is meaningful only while the block is accepting. They check that the ring head holds still across a stalled cycle, that done is a lone pulse with the result frozen between pulses, and that done stays low while operands are being accepted. The stimulus presents operands only after a start has been taken, with valid either solid or broken by periodic gaps. On purpose, it also drives junk data with valid high while idle and while draining, and a start pulse in the middle of a run, to show that the block ignores all of these.

// File: rtl/psum_pkg.sv
package psum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } acc_state_e;
endpackage

// File: rtl/psum_add_pipe.sv
// Adder with LAT register stages; the stages advance only when en_i is high.
module psum_add_pipe #(
  parameter int SUM_W = 40,
  parameter int LAT   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SUM_W-1:0] a_i,
  input  logic [SUM_W-1:0] b_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] stg_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < LAT; s++) stg_q[s] <= '0;
    end else if (clr_i) begin
      for (int s = 0; s < LAT; s++) stg_q[s] <= '0;
    end else if (en_i) begin
      stg_q[0] <= a_i + b_i;
      for (int s = 1; s < LAT; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sum_o = stg_q[LAT-1];
endmodule

// File: rtl/psum_ring_store.sv
// Storage slots that close the ring after the adder; zero slots when LAT == DEPTH.
module psum_ring_store #(
  parameter int SUM_W = 40,
  parameter int SLOTS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SUM_W-1:0] tail_i,
  output logic [SUM_W-1:0] head_o
);
  if (SLOTS == 0) begin : g_direct
    assign head_o = tail_i;
  end else begin : g_slots
    logic [SUM_W-1:0] slot_q [SLOTS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
      end else if (clr_i) begin
        for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
      end else if (en_i) begin
        slot_q[0] <= tail_i;
        for (int s = 1; s < SLOTS; s++) slot_q[s] <= slot_q[s-1];
      end
    end

    assign head_o = slot_q[SLOTS-1];
  end
endmodule

// File: rtl/psum_ctrl.sv
module psum_ctrl
  import psum_pkg::*;
#(
  parameter int SUM_W = 40,
  parameter int CNT_W = 16,
  parameter int DEPTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             valid_i,
  input  logic [SUM_W-1:0] head_i,
  output logic             ring_clr_o,
  output logic             ring_en_o,
  output logic             feed_o,
  output logic             busy_o,
  output logic [SUM_W-1:0] result_o,
  output logic             done_o
);
  localparam int DCW = $clog2(DEPTH + 1);

  acc_state_e       state_q;
  logic [CNT_W-1:0] remain_q;
  logic [DCW-1:0]   dcnt_q;
  logic [SUM_W-1:0] red_q;
  logic [SUM_W-1:0] red_nxt;

  assign red_nxt    = red_q + head_i;
  assign ring_clr_o = (state_q == ST_IDLE) && start_i;
  assign feed_o     = (state_q == ST_RUN);
  assign ring_en_o  = ((state_q == ST_RUN) && valid_i) || (state_q == ST_DRAIN);
  assign busy_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      dcnt_q   <= '0;
      red_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (count_i == '0) begin
              result_o <= '0;
              done_o   <= 1'b1;
            end else begin
              remain_q <= count_i;
              state_q  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (valid_i) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
              state_q <= ST_DRAIN;
              dcnt_q  <= DCW'(DEPTH);
              red_q   <= '0;
            end
          end
        end
        ST_DRAIN: begin
          red_q  <= red_nxt;
          dcnt_q <= dcnt_q - 1'b1;
          if (dcnt_q == DCW'(1)) begin
            result_o <= red_nxt;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psum_ring_accum.sv
module psum_ring_accum #(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 40,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 12,
  parameter int LAT    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  result_o,
  output logic              done_o
);
  localparam int SLOTS = DEPTH - LAT;

  logic             ring_clr, ring_en, feed, busy;
  logic [SUM_W-1:0] ring_head, add_out, add_a, add_b;

  // during drain zeros re-enter the ring while the head is reduced
  assign add_a = feed ? ring_head : '0;
  assign add_b = feed ? SUM_W'(data_i) : '0;

  psum_add_pipe #(.SUM_W(SUM_W), .LAT(LAT)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ring_clr),
    .en_i  (ring_en),
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (add_out)
  );

  psum_ring_store #(.SUM_W(SUM_W), .SLOTS(SLOTS)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ring_clr),
    .en_i  (ring_en),
    .tail_i(add_out),
    .head_o(ring_head)
  );

  psum_ctrl #(.SUM_W(SUM_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .count_i   (count_i),
    .valid_i   (valid_i),
    .head_i    (ring_head),
    .ring_clr_o(ring_clr),
    .ring_en_o (ring_en),
    .feed_o    (feed),
    .busy_o    (busy),
    .result_o  (result_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/psum_ring_accum_chk.sv
module psum_ring_accum_chk #(
  parameter int SUM_W = 40,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             valid_i,
  input logic             busy_i,
  input logic             run_i,
  input logic [SUM_W-1:0] head_i,
  input logic [SUM_W-1:0] result_o,
  input logic             done_o
);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r6_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && count_i == '0) |=> (done_o && result_o == '0));

  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !valid_i) |=> $stable(head_i));

  a_r8_quiet_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> !done_o);
endmodule

bind psum_ring_accum psum_ring_accum_chk #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .count_i (count_i),
  .valid_i (valid_i),
  .busy_i  (busy),
  .run_i   (feed),
  .head_i  (ring_head),
  .result_o(result_o),
  .done_o  (done_o)
);

// File: tb/psum_ring_accum_tb.sv
module psum_ring_accum_tb;
  localparam int DATA_W = 32;
  localparam int SUM_W  = 40;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 12;
  localparam int LAT    = 11;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  count_i = '0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [SUM_W-1:0]  result_o;
  logic              done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  psum_ring_accum #(
    .DATA_W(DATA_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .LAT(LAT)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .valid_i(valid_i), .data_i(data_i), .result_o(result_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_val(input bit big);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return big ? (32'hF000_0000 | lcg) : lcg;
  endfunction

  // n operands; gap_mod>0 drops valid every gap_mod-th cycle; junk drives
  // valid outside accepting; mid_start pulses start halfway through
  task automatic run_case(input int n, input int gap_mod, input bit junk,
                          input bit mid_start, input bit big, input string req);
    logic [63:0] exp = '0;
    logic [SUM_W-1:0] held;
    int i = 0;
    int cyc = 0;
    bit early_done = 0;
    bit early_pulse = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    count_i = CNT_W'(n);
    valid_i = junk;
    data_i  = 32'hDEAD_BEEF;
    @(negedge clk_i);
    start_i = 1'b0;
    if (n == 0) begin
      valid_i = 1'b0;
      check(done_o === 1'b1, {req, " R6 done after zero-count start"}, 64'(done_o), 64'd1);
      check(result_o === '0, {req, " R6 zero result"}, 64'(result_o), 64'd0);
      @(negedge clk_i);
      check(done_o === 1'b0, {req, " R7 single pulse"}, 64'(done_o), 64'd0);
      return;
    end
    while (i < n) begin
      if (gap_mod != 0 && (cyc % gap_mod) == gap_mod - 1) begin
        valid_i = 1'b0;
        data_i  = 32'hBAD0_0000 | 32'(cyc);
      end else begin
        valid_i = 1'b1;
        data_i  = next_val(big);
        exp    += 64'(data_i);
        i++;
      end
      start_i = mid_start && (i == n / 2 + 1);
      count_i = '0;
      if (done_o !== 1'b0) early_done = 1;
      cyc++;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    valid_i = junk;
    data_i  = 32'hFFFF_FFFF;
    for (int k = 1; k <= DEPTH; k++) begin
      if (k > 1) @(negedge clk_i);
      else @(negedge clk_i);
      if (k < DEPTH && done_o !== 1'b0) early_pulse = 1;
    end
    check(!early_done, {req, " R8 no done while accepting"}, 64'(early_done), 64'd0);
    check(!early_pulse, {req, " R3 no done before drain ends"}, 64'(early_pulse), 64'd0);
    check(done_o === 1'b1, {req, " R3 done at DEPTH edges after last operand"},
          64'(done_o), 64'd1);
    check(result_o === exp[SUM_W-1:0], {req, " R2 total"}, 64'(result_o),
          64'(exp[SUM_W-1:0]));
    held = result_o;
    @(negedge clk_i);
    check(done_o === 1'b0, {req, " R7 done is one cycle"}, 64'(done_o), 64'd0);
    repeat (3) @(negedge clk_i);
    check(result_o === held && done_o === 1'b0, {req, " R7 result held while idle"},
          64'(result_o), 64'(held));
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(done_o === 1'b0, "R1 done low in reset", 64'(done_o), 64'd0);
    check(result_o === '0, "R1 result zero in reset", 64'(result_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(done_o === 1'b0 && result_o === '0, "R1 idle after reset", 64'(result_o), 64'd0);

    run_case(1, 0, 0, 0, 0, "R10 single");
    run_case(5, 0, 0, 0, 0, "R10 short");
    run_case(DEPTH, 0, 0, 0, 0, "R10 equal depth");
    run_case(40, 0, 0, 0, 0, "R4 wrap continuous");
    run_case(30, 3, 0, 0, 0, "R5 gaps every third");
    run_case(17, 2, 0, 0, 0, "R5 alternating");
    run_case(0, 0, 0, 0, 0, "R6 empty");
    run_case(20, 0, 1, 1, 0, "R8 junk and mid start");
    run_case(7, 0, 0, 0, 0, "R9 fresh after prior run");
    run_case(600, 5, 0, 0, 1, "R2 modulo wrap");
    run_case(0, 0, 1, 0, 0, "R6 empty with junk valid");
    run_case(3, 0, 1, 0, 0, "R9 short after empty");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule